// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block holds the second control register of a real-time clock: one byte that mixes configuration bits with flags raised by hardware. Software writes the whole byte through a plain write strobe and reads it back at any time on a combinational read port. Each bit has its own write rule. The two configuration bits take whatever is written. The supply-low flag, the power-on flag and the three event flags only clear when a 0 is written to them, and a written 1 leaves them alone. The oscillator-ok bit accepts both values, but a halt detected by hardware forces it low.

While the supply-low flag is set, the supply monitor is switched off through `mon_en`, so the flag holds its value until software clears it. The power-on flag is raised by a power-on event. A power-on event wipes the register except the oscillator-ok bit and the power-on flag. When the power-on flag goes from 0 to 1, the block sends a one-cycle pulse that clears the neighbouring adjustment and control registers. The interrupt outputs stay disabled for as long as the flag is 1.

No data flows through this block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. A write takes effect in the cycle its strobe is sampled.

Top module: `rtc_status_reg`

Register layout (bit 7 down to bit 0, with the default `NUM_EVT = 3`):

| Bit | Field |
|-----|-------|
| 7 | threshold select |
| 6 | supply-low flag |
| 5 | oscillator-ok |
| 4 | power-on flag |
| 3 | control enable |
| 2 | counter event |
| 1 | alarm W event |
| 0 | alarm D event |

## Requirements
- R1: Out of reset the register reads 8'h10: the power-on flag (bit 4) is 1 and every other bit is 0. In this state `irq_en` is 0, `nbr_clr` is 0 and `mon_en` is 1.
- R2: Bit 7 (threshold select; 0 selects the higher supply threshold, 1 the lower one) and bit 3 (control enable) take the written value. `thr_sel` always equals bit 7.
- R3: When `vdd_low` is sampled high while the supply-low flag (bit 6) is 0, the flag becomes 1 at that edge. While the flag is 1, `mon_en` is 0 and the comparator input is ignored.
- R4: Writing 0 to bit 6 clears the supply-low flag, which enables the monitor again. Writing 1 to bit 6 has no effect.
- R5: When `osc_halt` is sampled high, bit 5 (oscillator-ok) becomes 0 and stays 0 after the halt ends. Writes may set bit 5 to 0 or 1. A halt beats a write of 1 in the same cycle.
- R6: A power-on event sets bit 4. Only a write of 0 clears bit 4; a write of 1 is ignored.
- R7: A power-on event clears bits 7, 6, 3 and 2:0 and leaves bit 5 unchanged. In that cycle it overrides any event and discards the whole write.
- R8: `nbr_clr` is high for exactly the first cycle in which the power-on flag reads 1 after having read 0. A power-on event while the flag is already 1, and reset itself, give no pulse.
- R9: `irq_en` is 0 whenever the power-on flag is 1, and 1 otherwise.
- R10: Event flags (bit 2 counter, bit 1 alarm W, bit 0 alarm D, set by `evt_in[2]`, `evt_in[1]`, `evt_in[0]` respectively) are sticky. A write of 0 clears a flag; a write of 1 leaves it unchanged.
- R11: If an event pulse and a write of 0 hit the same event flag in the same cycle, the flag ends up 1.
- R12: `rd_data` shows the register state without delay: a write or event sampled at an edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, models power-up from zero volts |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | NUM_EVT+5 | Byte to write |
| por_evt | input | 1 | Power-on event pulse |
| vdd_low | input | 1 | Comparator output, high while the supply is below the threshold |
| osc_halt | input | 1 | Oscillator halt detect |
| evt_in | input | NUM_EVT | Event pulses for the sticky flags |
| rd_data | output | NUM_EVT+5 | Current register contents |
| thr_sel | output | 1 | Supply threshold select |
| mon_en | output | 1 | Supply monitor enable |
| nbr_clr | output | 1 | One-cycle clear pulse to the adjustment and control-1 registers |
| irq_en | output | 1 | Interrupt output enable |

## Verification
Every stimulus the bench drives is sampled at the next rising edge. Its effect shows on `rd_data`, `thr_sel`, `mon_en`, `irq_en` and `nbr_clr` immediately after that edge, because all outputs are combinational from the state registers. The bench therefore changes inputs on the falling edge and compares all outputs on the following falling edge against a behavioural model, and it does this every cycle. The model advances at the same rising edge, so the comparison always covers exactly one register stage. The `nbr_clr` pulse is checked in the first falling-edge sample after the power-on flag rises, and checked to be gone one sample later.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  // fixed fields above the event flags, counted from the MSB
  localparam int FIXED_FIELDS = 5;
  localparam int OFS_THR  = 1;
  localparam int OFS_VLOW = 2;
  localparam int OFS_OSC  = 3;
  localparam int OFS_PON  = 4;
  localparam int OFS_CTL  = 5;
endpackage

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic set_i,
  input  logic wr_clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (clr_all) q <= 1'b0;
    else if (set_i)   q <= 1'b1;
    else if (wr_clr)  q <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_all) |=> q);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !wr_clr && !clr_all) |=> q);
endmodule

// File: rtl/rtc_pon_unit.sv
module rtc_pon_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic por_evt,
  input  logic wr_clr,
  output logic pon,
  output logic nbr_clr,
  output logic irq_en
);
  logic pon_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pon <= 1'b1;
    else if (por_evt) pon <= 1'b1;
    else if (wr_clr)  pon <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pon_d <= 1'b1;
    else        pon_d <= pon;
  end

  assign nbr_clr = pon & ~pon_d;
  assign irq_en  = ~pon;

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nbr_clr |=> !nbr_clr);
  // R6
  pon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pon && !wr_clr) |=> pon);
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_stat_pkg::*;
#(
  parameter int NUM_EVT = 3,
  localparam int REG_W  = NUM_EVT + FIXED_FIELDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               por_evt,
  input  logic               vdd_low,
  input  logic               osc_halt,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [REG_W-1:0]   rd_data,
  output logic               thr_sel,
  output logic               mon_en,
  output logic               nbr_clr,
  output logic               irq_en
);
  localparam int B_THR  = REG_W - OFS_THR;
  localparam int B_VLOW = REG_W - OFS_VLOW;
  localparam int B_OSC  = REG_W - OFS_OSC;
  localparam int B_PON  = REG_W - OFS_PON;
  localparam int B_CTL  = REG_W - OFS_CTL;

  logic               wr_eff;
  logic               thr_q, ctl_q, osc_q, vlow_q, pon_q;
  logic [NUM_EVT-1:0] evt_q;

  // a power-on event discards the whole write of that cycle
  assign wr_eff = wr_en & ~por_evt;

  // plain configuration bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      ctl_q <= 1'b0;
    end else if (por_evt) begin
      thr_q <= 1'b0;
      ctl_q <= 1'b0;
    end else if (wr_eff) begin
      thr_q <= wr_data[B_THR];
      ctl_q <= wr_data[B_CTL];
    end
  end

  // oscillator-ok: hardware halt beats software, survives power-on clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        osc_q <= 1'b0;
    else if (osc_halt) osc_q <= 1'b0;
    else if (wr_eff)   osc_q <= wr_data[B_OSC];
  end

  // supply-low flag; monitor frozen while set
  assign mon_en = ~vlow_q;

  rtc_sticky_flag u_vlow (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (por_evt),
    .set_i   (vdd_low & mon_en),
    .wr_clr  (wr_eff & ~wr_data[B_VLOW]),
    .q       (vlow_q)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    rtc_sticky_flag u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (por_evt),
      .set_i   (evt_in[i]),
      .wr_clr  (wr_eff & ~wr_data[i]),
      .q       (evt_q[i])
    );
  end

  rtc_pon_unit u_pon (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_evt (por_evt),
    .wr_clr  (wr_eff & ~wr_data[B_PON]),
    .pon     (pon_q),
    .nbr_clr (nbr_clr),
    .irq_en  (irq_en)
  );

  assign thr_sel = thr_q;
  assign rd_data = {thr_q, vlow_q, osc_q, pon_q, ctl_q, evt_q};

  // R5
  osc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_halt |=> !rd_data[B_OSC]);
  // R7
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (!thr_sel && !rd_data[B_VLOW] && !rd_data[B_CTL]
                 && rd_data[NUM_EVT-1:0] == '0 && !irq_en));
  // R3
  mon_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !por_evt && !(wr_en && !wr_data[B_VLOW])) |=> !mon_en);
endmodule

// File: tb/rtc_status_reg_test.sv
module rtc_status_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       por_evt = 1'b0;
  logic       vdd_low = 1'b0;
  logic       osc_halt = 1'b0;
  logic [2:0] evt_in = '0;
  logic [7:0] rd_data;
  logic       thr_sel, mon_en, nbr_clr, irq_en;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_status_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .por_evt(por_evt), .vdd_low(vdd_low), .osc_halt(osc_halt),
    .evt_in(evt_in), .rd_data(rd_data), .thr_sel(thr_sel),
    .mon_en(mon_en), .nbr_clr(nbr_clr), .irq_en(irq_en)
  );

  // behavioural reference model
  int m_thr, m_vl, m_osc, m_pon, m_ctl, m_pulse;
  int m_ev [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr = 0; m_vl = 0; m_osc = 0; m_pon = 1; m_ctl = 0; m_pulse = 0;
      for (int i = 0; i < 3; i++) m_ev[i] = 0;
    end else begin
      int old_pon, old_vl;
      old_pon = m_pon;
      old_vl  = m_vl;
      if (por_evt) begin
        m_pon = 1; m_thr = 0; m_vl = 0; m_ctl = 0;
        for (int i = 0; i < 3; i++) m_ev[i] = 0;
        if (osc_halt) m_osc = 0;
      end else begin
        if (wr_en) begin
          m_thr = wr_data[7];
          m_ctl = wr_data[3];
          m_osc = wr_data[5];
          if (!wr_data[6]) m_vl = 0;
          if (!wr_data[4]) m_pon = 0;
          for (int i = 0; i < 3; i++) if (!wr_data[i]) m_ev[i] = 0;
        end
        for (int i = 0; i < 3; i++) if (evt_in[i]) m_ev[i] = 1;
        if (old_vl == 0 && vdd_low) m_vl = 1;
        if (osc_halt) m_osc = 0;
      end
      m_pulse = (m_pon == 1 && old_pon == 0) ? 1 : 0;
    end
  end

  function automatic logic [7:0] model_byte();
    return {m_thr[0], m_vl[0], m_osc[0], m_pon[0], m_ctl[0],
            m_ev[2][0], m_ev[1][0], m_ev[0][0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 rd_data", rd_data, model_byte());
      chk("R2 thr_sel", thr_sel, m_thr);
      chk("R3 mon_en", mon_en, !m_vl);
      chk("R8 nbr_clr", nbr_clr, m_pulse);
      chk("R9 irq_en", irq_en, !m_pon);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(logic w, logic [7:0] d, logic por, logic low,
                      logic halt, logic [2:0] ev);
    wr_en = w; wr_data = d; por_evt = por; vdd_low = low;
    osc_halt = halt; evt_in = ev;
    @(negedge clk);
    wr_en = 0; por_evt = 0; vdd_low = 0; osc_halt = 0; evt_in = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset byte", rd_data, 8'h10);
    chk("R1 irq_en", irq_en, 0);
    chk("R1 nbr_clr", nbr_clr, 0);
    chk("R1 mon_en", mon_en, 1);

    step(1, 8'h88, 0, 0, 0, 3'b000);
    chk("R2 config write", rd_data, 8'h88);
    chk("R9 irq enabled", irq_en, 1);

    step(0, 8'h00, 0, 1, 0, 3'b000);
    chk("R3 low set", rd_data[6], 1);
    chk("R3 monitor off", mon_en, 0);

    step(1, 8'hFF, 0, 1, 0, 3'b000);
    chk("R4 R6 write ones", rd_data, 8'hE8);

    step(1, 8'hBF, 0, 0, 0, 3'b000);
    chk("R4 low cleared", rd_data, 8'hA8);

    step(0, 8'h00, 0, 0, 0, 3'b101);
    step(1, 8'hFE, 0, 0, 0, 3'b000);
    chk("R10 sticky clear", rd_data, 8'hAC);

    step(1, 8'hAC, 0, 0, 0, 3'b010);
    chk("R11 set beats clear", rd_data, 8'hAE);

    step(1, 8'hFF, 0, 0, 1, 3'b000);
    chk("R5 halt wins", rd_data, 8'h8E);

    step(0, 8'h00, 1, 0, 0, 3'b001);
    chk("R7 power-on clear", rd_data, 8'h10);
    chk("R8 pulse high", nbr_clr, 1);
    chk("R9 irq gated", irq_en, 0);
    @(negedge clk);
    chk("R8 pulse gone", nbr_clr, 0);

    step(0, 8'h00, 1, 0, 0, 3'b000);
    chk("R8 no repeat pulse", nbr_clr, 0);

    step(1, 8'h20, 0, 0, 0, 3'b000);
    chk("R6 pon cleared", rd_data, 8'h20);

    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 1) == 0, 8'($urandom),
           $urandom_range(0, 40) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 9) == 0, 3'($urandom) & 3'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule